// File: doc/BRIEF.md
# USB IN Endpoint Status Controller

This block holds the control and status state of one device-side USB IN endpoint whose packet buffer can hold up to two packets. For each IN token reported by the serial engine it picks the handshake: a data packet carrying the current DATA0/DATA1 toggle, a STALL, a NAK, or a zero-length packet. It tracks how many packets are queued, keeps the data toggle and holds three sticky status flags.

Software sees one 8-bit control/status register. Some bits trigger an action when written with 1 and always read back 0. Some flags can only be cleared by writing 0. One bit is plain read/write. Packet-ready is set by software and cleared by the hardware. Token and packet-sent inputs are one-cycle strobes. The block accepts every strobe: it has no ready signal and applies no back-pressure.

Register bits (read view): 0 packet-ready, 1 buffer-not-empty, 2 underrun, 3 discard (write-1 trigger, reads 0), 4 force-stall, 5 stall-sent, 6 toggle-reset (write-1 trigger, reads 0), 7 reserved (reads 0). A write updates all writable bits at once, so software writes 1 to any sticky flag it wants to keep.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `resp_valid` is 0 and `data_toggle` is 0.
- R2: A register write with bit 6 set resets `data_toggle` to 0 (DATA0). Bit 6 always reads back 0.
- R3: A token received while force-stall (bit 4) is 1 on a non-isochronous endpoint is answered with STALL (`resp_code` 2'b01). It also sets stall-sent (bit 5), empties the buffer and clears packet-ready. `data_toggle` does not change.
- R4: On an isochronous endpoint (`xfer_type` 2'b01), force-stall has no effect. A queued packet is still sent as data (`resp_code` 2'b00).
- R5: A write with bit 3 set discards exactly one queued packet. On an empty buffer it does nothing, and bit 3 always reads back 0.
- R6: A token on an empty non-isochronous endpoint gets a NAK (`resp_code` 2'b10) and sets underrun (bit 2).
- R7: A token on an empty isochronous endpoint gets a zero-length packet (`resp_code` 2'b11) and sets underrun.
- R8: The sticky flags (bits 1, 2 and 5) are cleared by writing 0 and are left unchanged by writing 1. When a hardware set and a software clear fall in the same cycle, the set wins.
- R9: Buffer-not-empty (bit 1) is set in every cycle in which at least one packet is queued.
- R10: With single buffering (`dbl_buf_en`=0), writing 1 to bit 0 queues a packet and sets packet-ready. Packet-ready clears when `pkt_sent` reports the packet gone. A write of bit 0 while a packet is already queued is ignored.
- R11: With double buffering, up to two packets are queued. Packet-ready reads 1 only while both slots are full, and a write of bit 0 with two packets queued is ignored.
- R12: A data response carries the current toggle on `resp_data1`. `pkt_sent` on a non-isochronous endpoint flips `data_toggle`. On an isochronous endpoint it leaves the toggle unchanged.
- R13: Each token produces exactly one response: `resp_valid` is high for a single cycle, in the cycle after the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 7 | Write data, bits 6..0 of the register |
| reg_rd_data | output | 8 | Current register value |
| xfer_type | input | 2 | 2'b01 isochronous, any other value bulk/interrupt |
| dbl_buf_en | input | 1 | Double-buffer enable |
| tok_in | input | 1 | IN token received strobe |
| pkt_sent | input | 1 | Queued data packet transmitted and acknowledged |
| resp_valid | output | 1 | Handshake decision valid |
| resp_code | output | 2 | 00 data, 01 STALL, 10 NAK, 11 zero-length |
| resp_data1 | output | 1 | Toggle for the data response (1 = DATA1) |
| data_toggle | output | 1 | Current endpoint data toggle |

## Verification
Register writes, token strobes and `pkt_sent` all take effect at the next rising edge. The register view and `data_toggle` change in the cycle after the stimulus, and a response is valid only in that cycle. The bench drives every stimulus for one cycle starting at a falling edge and samples at the next falling edge, one full register stage later. For each token it also checks the following falling edge, to confirm that `resp_valid` has dropped again. Buffer occupancy is never read directly: the bench infers it from packet-ready and from whether the next token gets data or a NAK.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    HS_DATA  = 2'b00,
    HS_STALL = 2'b01,
    HS_NAK   = 2'b10,
    HS_ZLP   = 2'b11
  } hs_e;

  localparam logic [1:0] XFER_ISO = 2'b01;

  localparam int B_RDY    = 0;
  localparam int B_NEMPTY = 1;
  localparam int B_UNDER  = 2;
  localparam int B_DISC   = 3;
  localparam int B_FSTALL = 4;
  localparam int B_SSENT  = 5;
  localparam int B_TGLRST = 6;
endpackage

// File: rtl/ep_occupancy.sv
module ep_occupancy #(
  parameter int MAX_PKTS = 2,
  localparam int CW = $clog2(MAX_PKTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl_buf_en,
  input  logic          load_req,
  input  logic          sent_req,
  input  logic          disc_req,
  input  logic          stall_flush,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next,
  output logic          pkt_ready
);
  localparam logic [CW-1:0] FULL2 = CW'(MAX_PKTS);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cap;
  logic          ready_next;

  always_comb begin
    cap        = dbl_buf_en ? FULL2 : ONE;
    count_next = count;
    if (sent_req && count_next != '0) count_next = count_next - ONE;
    if (disc_req && count_next != '0) count_next = count_next - ONE;
    if (load_req && count_next < cap) count_next = count_next + ONE;
    if (stall_flush) count_next = '0;
    ready_next = dbl_buf_en ? (count_next == FULL2) : (count_next != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      pkt_ready <= 1'b0;
    end else begin
      count     <= count_next;
      pkt_ready <= ready_next;
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL2);

  a_r5_discard_one: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_req && !sent_req && !load_req && !stall_flush && count != '0)
      |=> count == $past(count) - ONE);

  a_r3_stall_empties: assert property (@(posedge clk) disable iff (!rst_n)
    stall_flush |=> (count == '0) && !pkt_ready);
endmodule

// File: rtl/ep_data_toggle.sv
module ep_data_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic toggle
);
  always_ff @(posedge clk) begin
    if (!rst_n)    toggle <= 1'b0;
    else if (clr)  toggle <= 1'b0;
    else if (flip) toggle <= ~toggle;
  end

  a_r2_reset_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !toggle);

  a_r12_hold_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !flip) |=> toggle == $past(toggle));
endmodule

// File: rtl/ep_token_resp.sv
module ep_token_resp
  import usb_in_ep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  input  logic iso,
  input  logic force_stall,
  input  logic empty,
  input  logic toggle,
  output logic stall_evt,
  output logic under_evt,
  output logic resp_valid,
  output hs_e  resp_code,
  output logic resp_data1
);
  hs_e code_c;

  always_comb begin
    stall_evt = 1'b0;
    under_evt = 1'b0;
    code_c    = HS_DATA;
    if (tok_in) begin
      if (force_stall && !iso) begin
        stall_evt = 1'b1;
        code_c    = HS_STALL;
      end else if (empty) begin
        under_evt = 1'b1;
        code_c    = iso ? HS_ZLP : HS_NAK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= HS_DATA;
      resp_data1 <= 1'b0;
    end else begin
      resp_valid <= tok_in;
      if (tok_in) begin
        resp_code  <= code_c;
        resp_data1 <= toggle;
      end
    end
  end

  a_r13_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in |=> resp_valid);
  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_in |=> !resp_valid);
  a_r3_stall_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && force_stall && !iso) |=> resp_code == HS_STALL);
  a_r4_iso_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && iso) |=> resp_code != HS_STALL);
  a_r6_nak_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !iso && !force_stall && empty) |=> resp_code == HS_NAK);
  a_r7_zlp_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && iso && empty) |=> resp_code == HS_ZLP);
endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg #(
  parameter int NFLAGS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_stall,
  input  logic [NFLAGS-1:0] wr_keep,
  input  logic [NFLAGS-1:0] set_evt,
  output logic [NFLAGS-1:0] flags,
  output logic              force_stall
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)     flags[i] <= 1'b0;
      else if (wr_en) flags[i] <= set_evt[i] | (flags[i] & wr_keep[i]);
      else            flags[i] <= set_evt[i] | flags[i];
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    a_r8_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && (!wr_en || wr_keep[i])) |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     force_stall <= 1'b0;
    else if (wr_en) force_stall <= wr_stall;
  end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int MAX_PKTS = 2,
  localparam int CW = $clog2(MAX_PKTS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [6:0] reg_wr_data,
  output logic [7:0] reg_rd_data,
  input  logic [1:0] xfer_type,
  input  logic       dbl_buf_en,
  input  logic       tok_in,
  input  logic       pkt_sent,
  output logic       resp_valid,
  output logic [1:0] resp_code,
  output logic       resp_data1,
  output logic       data_toggle
);
  logic          iso;
  logic [CW-1:0] count, count_next;
  logic          pkt_ready, force_stall;
  logic          stall_evt, under_evt;
  logic          load_req, disc_req, sent_req, tgl_clr, tgl_flip;
  logic [2:0]    flags, set_evt, wr_keep;
  hs_e           code_q;

  assign iso      = (xfer_type == XFER_ISO);
  assign load_req = reg_wr_en && reg_wr_data[B_RDY];
  assign disc_req = reg_wr_en && reg_wr_data[B_DISC];
  assign tgl_clr  = reg_wr_en && reg_wr_data[B_TGLRST];
  assign sent_req = pkt_sent && (count != '0) && !stall_evt;
  assign tgl_flip = sent_req && !iso;

  ep_occupancy #(.MAX_PKTS(MAX_PKTS)) u_occ (
    .clk(clk), .rst_n(rst_n), .dbl_buf_en(dbl_buf_en),
    .load_req(load_req), .sent_req(sent_req), .disc_req(disc_req),
    .stall_flush(stall_evt), .count(count), .count_next(count_next),
    .pkt_ready(pkt_ready)
  );

  ep_data_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .clr(tgl_clr), .flip(tgl_flip),
    .toggle(data_toggle)
  );

  ep_token_resp u_resp (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .iso(iso),
    .force_stall(force_stall), .empty(count == '0), .toggle(data_toggle),
    .stall_evt(stall_evt), .under_evt(under_evt),
    .resp_valid(resp_valid), .resp_code(code_q), .resp_data1(resp_data1)
  );

  // flag order: 0 buffer-not-empty, 1 underrun, 2 stall-sent
  assign set_evt = {stall_evt, under_evt, count_next != '0};
  assign wr_keep = {reg_wr_data[B_SSENT], reg_wr_data[B_UNDER], reg_wr_data[B_NEMPTY]};

  ep_status_reg #(.NFLAGS(3)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en),
    .wr_stall(reg_wr_data[B_FSTALL]), .wr_keep(wr_keep), .set_evt(set_evt),
    .flags(flags), .force_stall(force_stall)
  );

  assign resp_code = code_q;
  always_comb begin
    reg_rd_data           = '0;
    reg_rd_data[B_RDY]    = pkt_ready;
    reg_rd_data[B_NEMPTY] = flags[0];
    reg_rd_data[B_UNDER]  = flags[1];
    reg_rd_data[B_FSTALL] = force_stall;
    reg_rd_data[B_SSENT]  = flags[2];
  end

  a_r9_nonempty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> reg_rd_data[B_NEMPTY]);
  a_r3_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == HS_STALL) |-> reg_rd_data[B_SSENT] && !reg_rd_data[B_RDY]);
  a_r5_trigger_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[B_DISC] && !reg_rd_data[B_TGLRST] && !reg_rd_data[7]);
endmodule

// File: tb/usb_in_ep_ctrl_test.sv
module usb_in_ep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [6:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic [1:0] xfer_type = 2'b10;
  logic       dbl_buf_en = 1'b0;
  logic       tok_in = 1'b0;
  logic       pkt_sent = 1'b0;
  logic       resp_valid;
  logic [1:0] resp_code;
  logic       resp_data1;
  logic       data_toggle;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [1:0] C_DATA = 2'b00, C_STALL = 2'b01, C_NAK = 2'b10, C_ZLP = 2'b11;

  always #2.5 clk = ~clk;

  usb_in_ep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .xfer_type(xfer_type), .dbl_buf_en(dbl_buf_en),
    .tok_in(tok_in), .pkt_sent(pkt_sent), .resp_valid(resp_valid),
    .resp_code(resp_code), .resp_data1(resp_data1), .data_toggle(data_toggle)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic token(input string tag, input logic [1:0] code);
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
    chk({tag, " resp_valid"}, {7'd0, resp_valid}, 8'h01);
    chk({tag, " resp_code"}, {6'd0, resp_code}, {6'd0, code});
    @(negedge clk);
    chk({tag, " R13 single pulse"}, {7'd0, resp_valid}, 8'h00);
  endtask

  task automatic sent();
    @(negedge clk); pkt_sent = 1'b1;
    @(negedge clk); pkt_sent = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reg", reg_rd_data, 8'h00);
    chk("R1 resp_valid", {7'd0, resp_valid}, 8'h00);
    chk("R1 toggle", {7'd0, data_toggle}, 8'h00);
  endtask

  task automatic t_single_bulk();
    xfer_type = 2'b10; dbl_buf_en = 1'b0;
    wr(7'h01); chk("R10 R9 load sets ready", reg_rd_data, 8'h03);
    wr(7'h03); chk("R10 second load ignored", reg_rd_data, 8'h03);
    token("R12 data", C_DATA);
    chk("R12 resp_data1", {7'd0, resp_data1}, 8'h00);
    sent();
    chk("R10 ready clears on sent", reg_rd_data, 8'h02);
    chk("R12 toggle flips", {7'd0, data_toggle}, 8'h01);
    token("R6 nak", C_NAK);
    chk("R6 underrun", reg_rd_data, 8'h06);
    wr(7'h02); chk("R8 write0 clears, write1 keeps", reg_rd_data, 8'h02);
    wr(7'h00); chk("R8 clear all", reg_rd_data, 8'h00);
  endtask

  task automatic t_toggle_reset();
    wr(7'h40);
    chk("R2 toggle reset", {7'd0, data_toggle}, 8'h00);
    chk("R2 bit reads 0", reg_rd_data, 8'h00);
  endtask

  task automatic t_double();
    xfer_type = 2'b11; dbl_buf_en = 1'b1;
    wr(7'h01); chk("R11 one queued, ready low", reg_rd_data, 8'h02);
    wr(7'h01); chk("R11 two queued, ready high", reg_rd_data, 8'h03);
    wr(7'h01); chk("R11 third load ignored", reg_rd_data, 8'h03);
    wr(7'h0A); chk("R5 discard one", reg_rd_data, 8'h02);
    wr(7'h0A); chk("R5 discard second", reg_rd_data, 8'h02);
    token("R5 R11 empty after two discards", C_NAK);
    chk("R6 underrun dbl", reg_rd_data, 8'h06);
    wr(7'h08); chk("R5 discard on empty", reg_rd_data, 8'h00);
    wr(7'h01); chk("R5 no underflow", reg_rd_data, 8'h02);
    token("R5 data after empty discard", C_DATA);
    chk("R12 resp_data1 zero", {7'd0, resp_data1}, 8'h00);
    sent();
    chk("R12 toggle flips dbl", {7'd0, data_toggle}, 8'h01);
    chk("R9 flag sticky", reg_rd_data, 8'h02);
  endtask

  task automatic t_stall();
    wr(7'h00);
    xfer_type = 2'b10; dbl_buf_en = 1'b1;
    wr(7'h01); wr(7'h01);
    wr(7'h12); chk("R3 force-stall set", reg_rd_data, 8'h13);
    token("R3 stall", C_STALL);
    chk("R3 flags after stall", reg_rd_data, 8'h32);
    chk("R3 toggle unchanged", {7'd0, data_toggle}, 8'h01);
    wr(7'h00); chk("R8 clear stall-sent", reg_rd_data, 8'h00);
    token("R3 buffer emptied", C_NAK);
    chk("R6 underrun after stall", reg_rd_data, 8'h04);
    @(negedge clk); tok_in = 1'b1; reg_wr_en = 1'b1; reg_wr_data = 7'h00;
    @(negedge clk); tok_in = 1'b0; reg_wr_en = 1'b0;
    chk("R8 set wins over clear", reg_rd_data, 8'h04);
    chk("R6 nak same cycle", {6'd0, resp_code}, {6'd0, C_NAK});
  endtask

  task automatic t_iso();
    wr(7'h00);
    xfer_type = 2'b01; dbl_buf_en = 1'b0;
    token("R7 zlp", C_ZLP);
    chk("R7 underrun", reg_rd_data, 8'h04);
    wr(7'h11); chk("R4 load with stall", reg_rd_data, 8'h13);
    token("R4 stall ignored iso", C_DATA);
    chk("R12 resp_data1 one", {7'd0, resp_data1}, 8'h01);
    sent();
    chk("R12 iso toggle held", {7'd0, data_toggle}, 8'h01);
    chk("R10 iso ready cleared", reg_rd_data, 8'h12);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_bulk();
    t_toggle_reset();
    t_double();
    t_stall();
    t_iso();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule